// File: doc/BRIEF.md
# Clocked Serial Master Receiver

This block receives bytes over a three-wire style synchronous link on which it is the clock master. It generates the serial clock from the system clock with a fixed divider, samples the serial data input on each rising edge of that clock, and assembles 8-bit bytes with the most significant bit first. Software controls it through a small register bus: a control register with an enable bit and a stop-request bit, a status register with data-full, overrun and busy flags, and a receive data register.

Reception is driven by reads. While the unit is enabled and idle, a read of the data register (the first one being a dummy read) starts a byte. After each byte the unit goes on to the next byte by itself, unless the stop request is set or an overrun is pending. Software ends a burst by setting the stop request while the last byte is in flight, then clearing enable and stop before it reads that last byte. Flow control is done with flags and not with a handshake. The data-full flag means a byte is waiting, and the register read clears it. If a byte finishes while the previous one is still unread, the overrun flag is set and all transfers stop until software clears that flag.

Register map (2-bit address): 0 = control (bit0 enable, bit1 stop request, read/write); 1 = status (bit0 data full, bit1 overrun, bit2 busy; only bit1 can be written); 2 = receive data (read only); 3 reads as zero. A bus access takes effect at the clock edge where `bus_sel` is high. `bus_wr` high makes it a write and low makes it a read. Read data is combinational from the address.

Top module: `srx_master`

## Requirements
- R1: After reset the serial clock is high (idle), the control register reads 0 and the status register reads 0.
- R2: A data-register read while the enable bit (control bit0) is 1, the overrun flag is 0 and the unit is idle starts a byte. With enable 0, a data-register read starts nothing and the serial clock stays high.
- R3: Each byte is 8 bits and is taken MSB first. Each bit is sampled at a rising serial clock edge. The byte is loaded into the data register and data full (status bit0) is set at the edge that samples the eighth bit.
- R4: A read of the data register clears data full.
- R5: At the end of a byte the unit starts the next byte without a further read if enable is 1, overrun is 0 and the stop request (control bit1) is 0. With the stop request set, it finishes the byte in progress and starts no further byte.
- R6: A data-register read while enabled and idle starts a new byte even when the stop request is 1. Clearing enable and stop before reading the final byte produces no extra clock pulses.
- R7: If a byte completes while data full is 1 (and the data register is not being read in that cycle), the byte is discarded, the data register keeps its value and the overrun flag (status bit1) is set. While overrun is 1, no byte starts.
- R8: Overrun is cleared only by a status read that sees it at 1, followed by a status write with bit1 = 0. Such a write with no prior read leaves it at 1.
- R9: Clearing enable during a byte aborts the byte at the next half-period boundary. The clock returns high, and neither data full nor overrun is set.
- R10: Busy (status bit2) is 1 from the edge on which the clock first falls for a byte until the eighth bit is sampled. Busy is 1 whenever the serial clock is low.
- R11: The serial clock is low for DIV/2 and high for DIV/2 system clocks per bit, so one byte holds the clock low for 8*DIV/2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sclk_o | output | 1 | Generated serial clock, idles high |
| sdi_i | input | 1 | Serial data input |

## Verification
The bound checker checks the flag rules on every cycle: a finished byte sets data full, a data read clears it, an overrun keeps the data register unchanged, no byte leaves idle while overrun is set, an abort touches no flag, busy covers every low clock phase, and a low phase never lasts only one cycle. Only the bench's scenarios can show the sequences that span many bytes: MSB-first assembly against a serial source, a burst ended by the stop request with an exact count of clock pulses, a restart caused by a read while enabled, the two-step overrun clear, and the total low time of the clock for one byte.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  // control bits
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_STOP = 1;
  // status bits
  localparam int unsigned S_FULL = 0;
  localparam int unsigned S_OVR  = 1;
  localparam int unsigned S_BUSY = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen
  import srx_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   cont,
  input  logic   run_en,
  input  logic   frame_end,
  output logic   sclk,
  output phase_e phase,
  output logic   sample,
  output logic   abort,
  output logic   consume
);
  localparam int unsigned HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  phase_e        st_d;
  logic          last;

  assign last = (cnt == CW'(HALF - 1));

  always_comb begin
    st_d    = phase;
    sample  = 1'b0;
    abort   = 1'b0;
    consume = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (go) begin
          st_d    = PH_LOW;
          consume = 1'b1;
        end
      end
      PH_LOW: begin
        if (last) begin
          if (run_en) begin
            st_d   = PH_HIGH;
            sample = 1'b1;
          end else begin
            st_d  = PH_IDLE;
            abort = 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (last) begin
          if (frame_end) begin
            if (cont) begin
              st_d    = PH_LOW;
              consume = 1'b1;
            end else begin
              st_d = PH_IDLE;
            end
          end else if (run_en) begin
            st_d = PH_LOW;
          end else begin
            st_d  = PH_IDLE;
            abort = 1'b1;
          end
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      sclk  <= 1'b1;
    end else begin
      phase <= st_d;
      sclk  <= (st_d != PH_LOW);
      if (st_d != phase || phase == PH_IDLE) cnt <= '0;
      else                                   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         abort,
  input  logic         sdi,
  output logic         frame_end,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int unsigned BW = $clog2(W);

  logic [BW-1:0] bitcnt;
  logic [W-2:0]  sh;

  assign frame_end = (bitcnt == '0);
  assign done      = sample && (bitcnt == BW'(W - 1));
  assign word      = {sh, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
    end else if (abort) begin
      bitcnt <= '0;
    end else if (sample) begin
      sh     <= word[W-2:0];
      bitcnt <= (bitcnt == BW'(W - 1)) ? '0 : bitcnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              done,
  input  logic [W-1:0]      word,
  input  logic              busy,
  input  logic              idle,
  input  logic              consume,
  output logic              rx_en,
  output logic              go,
  output logic              cont,
  output logic              rd_data,
  output logic              rx_full,
  output logic              ovr,
  output logic [W-1:0]      rx_data
);
  logic stop, kick, arm;
  logic rd_stat, wr_ctrl, wr_stat, overrun, load;

  assign rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_sel &&  bus_wr && (bus_addr == A_STAT);

  assign overrun = done && rx_full && !rd_data;
  assign load    = done && !overrun;

  assign go   = kick && rx_en && !ovr;
  assign cont = rx_en && !ovr && (!stop || kick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      stop  <= 1'b0;
    end else if (wr_ctrl) begin
      rx_en <= bus_wdata[C_EN];
      stop  <= bus_wdata[C_STOP];
    end
  end

  // read-started transfer request, only accepted while fully idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick <= 1'b0;
    else        kick <= (kick && !consume && rx_en) || (rd_data && rx_en && !ovr && idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_data <= '0;
    end else if (load) begin
      rx_full <= 1'b1;
      rx_data <= word;
    end else if (rd_data) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0;
      arm <= 1'b0;
    end else if (overrun) begin
      ovr <= 1'b1;
      arm <= 1'b0;
    end else if (wr_stat && arm && !bus_wdata[S_OVR]) begin
      ovr <= 1'b0;
      arm <= 1'b0;
    end else if (rd_stat && ovr) begin
      arm <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[C_EN]   = rx_en;
        bus_rdata[C_STOP] = stop;
      end
      A_STAT: begin
        bus_rdata[S_FULL] = rx_full;
        bus_rdata[S_OVR]  = ovr;
        bus_rdata[S_BUSY] = busy;
      end
      A_DATA:  bus_rdata[W-1:0] = rx_data;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/srx_master.sv
module srx_master
  import srx_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sclk_o,
  input  logic              sdi_i
);
  localparam int unsigned W = REG_W;

  phase_e       phase;
  logic         go, cont, rx_en, sample, abort, consume;
  logic         frame_end, done, busy, idle, rd_data, rx_full, ovr;
  logic [W-1:0] word, rx_data;

  assign idle = (phase == PH_IDLE);
  assign busy = (phase == PH_LOW) || (phase == PH_HIGH && !frame_end);

  srx_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .go(go), .cont(cont), .run_en(rx_en),
    .frame_end(frame_end), .sclk(sclk_o), .phase(phase), .sample(sample),
    .abort(abort), .consume(consume)
  );

  srx_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sample(sample), .abort(abort), .sdi(sdi_i),
    .frame_end(frame_end), .done(done), .word(word)
  );

  srx_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .word(word), .busy(busy), .idle(idle), .consume(consume),
    .rx_en(rx_en), .go(go), .cont(cont), .rd_data(rd_data),
    .rx_full(rx_full), .ovr(ovr), .rx_data(rx_data)
  );
endmodule

// File: rtl/srx_master_chk.sv
module srx_master_chk #(
  parameter int unsigned DIV = 4,
  parameter int unsigned W   = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sclk_o,
  input logic         busy,
  input logic         idle,
  input logic         done,
  input logic         abort,
  input logic         rd_data,
  input logic         rx_full,
  input logic         ovr,
  input logic [W-1:0] rx_data
);
  localparam bit LONG_HALF = (DIV / 2) > 1;

  p_done_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full);

  p_read_clears_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rx_full);

  p_overrun_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_data) |=> (ovr && $stable(rx_data)));

  p_no_start_in_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && idle) |=> idle);

  p_abort_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !ovr || $past(ovr));

  p_low_means_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o |-> busy);

  p_low_half_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (LONG_HALF && $fell(sclk_o)) |=> !sclk_o);
endmodule

bind srx_master srx_master_chk #(.DIV(DIV), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .busy(busy), .idle(idle),
  .done(done), .abort(abort), .rd_data(rd_data), .rx_full(rx_full),
  .ovr(ovr), .rx_data(rx_data)
);

// File: tb/sim_srx_master.sv
module sim_srx_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sclk_o;
  logic       sdi_i = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // serial source model and observers
  logic [7:0] slv_bytes [4];
  int fall_cnt = 0, fall_base = 0;
  int rise_cnt = 0, rise_base = 0;
  int low_cnt  = 0, low_base  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srx_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .sdi_i(sdi_i)
  );

  always @(negedge sclk_o) begin
    int k;
    k = fall_cnt - fall_base;
    sdi_i <= slv_bytes[(k / 8) % 4][7 - (k % 8)];
    fall_cnt <= fall_cnt + 1;
  end
  always @(posedge sclk_o) rise_cnt <= rise_cnt + 1;
  always @(posedge clk) if (rst_n && sclk_o === 1'b0) low_cnt <= low_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rebase();
    fall_base = fall_cnt;
    rise_base = rise_cnt;
    low_base  = low_cnt;
  endtask

  function automatic int rises();
    return rise_cnt - rise_base;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_full(input string req);
    logic [7:0] s;
    int polls = 0;
    s = 8'd0;
    while (!s[0] && polls < 300) begin
      bus_read(2'd1, s);
      polls++;
    end
    chk(s[0], req, s, 8'h01);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(sclk_o === 1'b1, "R1 sclk idle", sclk_o, 1);
    bus_read(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    bus_read(2'd1, v); chk(v == 8'h00, "R1 stat", v, 8'h00);
  endtask

  task automatic t_disabled_read();
    logic [7:0] v;
    rebase();
    bus_read(2'd2, v);
    idle_cycles(40);
    chk(rises() == 0 && sclk_o === 1'b1, "R2 no start when disabled", rises(), 0);
  endtask

  task automatic t_single_byte();
    logic [7:0] v;
    slv_bytes[0] = 8'hA5;
    rebase();
    bus_write(2'd0, 8'h03);
    bus_read(2'd2, v);
    idle_cycles(10);
    bus_read(2'd1, v);
    chk(v[2] == 1'b1, "R10 busy mid-byte", v, 8'h04);
    wait_full("R3 full after byte");
    bus_read(2'd1, v);
    chk(v == 8'h01, "R10 busy drops at eighth bit", v, 8'h01);
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, v);
    chk(v == 8'hA5, "R3 msb-first byte", v, 8'hA5);
    bus_read(2'd1, v);
    chk(v == 8'h00, "R4 read clears full", v, 8'h00);
    idle_cycles(40);
    chk(rises() == 8, "R6 no extra transfer after clearing", rises(), 8);
    chk(low_cnt - low_base == 8 * (DIV/2), "R11 low time per byte", low_cnt - low_base, 8 * (DIV/2));
  endtask

  task automatic t_burst_stop();
    logic [7:0] v;
    slv_bytes[0] = 8'h3C; slv_bytes[1] = 8'hC3;
    rebase();
    bus_write(2'd0, 8'h01);
    bus_read(2'd2, v);
    wait_full("R5 first of burst");
    bus_read(2'd2, v);
    chk(v == 8'h3C, "R5 burst byte0", v, 8'h3C);
    bus_write(2'd0, 8'h03);
    wait_full("R5 second of burst");
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, v);
    chk(v == 8'hC3, "R5 burst byte1", v, 8'hC3);
    idle_cycles(60);
    chk(rises() == 16, "R5 stop ends burst", rises(), 16);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    slv_bytes[0] = 8'h5A; slv_bytes[1] = 8'h96;
    rebase();
    bus_write(2'd0, 8'h03);
    bus_read(2'd2, v);
    wait_full("R6 first byte");
    idle_cycles(4);
    bus_read(2'd2, v);
    chk(v == 8'h5A, "R6 first value", v, 8'h5A);
    wait_full("R6 restarted byte");
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, v);
    chk(v == 8'h96 && rises() == 16, "R6 read while enabled restarts", v, 8'h96);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    slv_bytes[0] = 8'h11; slv_bytes[1] = 8'h22; slv_bytes[2] = 8'h33;
    rebase();
    bus_write(2'd0, 8'h01);
    bus_read(2'd2, v);
    idle_cycles(120);
    chk(rises() == 16, "R7 transfers halt on overrun", rises(), 16);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v);
    chk(v == 8'h03, "R8 write without read keeps overrun", v, 8'h03);
    bus_read(2'd2, v);
    chk(v == 8'h11, "R7 data kept on overrun", v, 8'h11);
    idle_cycles(40);
    chk(rises() == 16, "R7 read starts nothing in overrun", rises(), 16);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v);
    chk(v == 8'h00, "R8 overrun cleared", v, 8'h00);
    bus_write(2'd0, 8'h03);
    bus_read(2'd2, v);
    wait_full("R8 transfers resume");
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, v);
    chk(v == 8'h33 && rises() == 24, "R8 byte after clear", v, 8'h33);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    slv_bytes[0] = 8'hFF;
    rebase();
    bus_write(2'd0, 8'h01);
    bus_read(2'd2, v);
    idle_cycles(14);
    bus_write(2'd0, 8'h00);
    idle_cycles(20);
    chk(sclk_o === 1'b1, "R9 clock idle after abort", sclk_o, 1);
    chk(rises() > 0 && rises() < 8, "R9 partial byte only", rises(), 4);
    bus_read(2'd1, v);
    chk(v == 8'h00, "R9 no flag after abort", v, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) slv_bytes[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(2);
    t_reset();
    t_disabled_read();
    t_single_byte();
    t_burst_stop();
    t_restart();
    t_overrun();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule